// File: doc/BRIEF.md
# Paced Single-Channel DMA Engine

This block is one DMA channel that copies a programmed number of units from a source address to a destination address. Software loads a source address, a destination address and a cycle count through a four-word register window, then writes the control word with the enable bit set. The sequencer reads one unit through a valid/ready read port and writes it through a valid/ready write port. After each beat it moves both addresses by a signed, programmable step. When the count reaches zero the channel raises a finish status. A bus error response raises an error status instead. Either status can drive the single level interrupt.

Each side can be paced by one of fifteen peripheral request lines. A channel whose line number is nonzero waits before every cycle until the request is high. When the cycle is done it pulses the matching grant for one clock. The count register counts down as cycles complete, so software can read the remaining work at any time. In burst mode a counted cycle is four beats and the address steps are four times larger.

The sequencer has seven states:
- `S_IDLE` goes to `S_WAIT` when enabled with a nonzero count, or to `S_FINISH` when enabled with a zero count.
- `S_WAIT` goes to `S_READ` once the selected requests are present, or back to `S_IDLE` if the enable has been cleared.
- `S_READ` goes to `S_WRITE` on a clean read handshake, or to `S_FAULT` on an error response.
- `S_WRITE` goes back to `S_READ` for the next beat of a burst, to `S_CLOSE` after the last beat, or to `S_FAULT` on an error response.
- `S_CLOSE` decrements the count and pulses the grants. It goes to `S_FINISH` if that was the last cycle, otherwise to `S_WAIT`.
- `S_FINISH` sets the finish status, clears the enable and returns to `S_IDLE`.
- `S_FAULT` sets the error status, clears the enable and returns to `S_IDLE`.

Top module: `pdma_channel`

## Requirements
- R1: After reset all four registers read 0, the irq output is low, and no read, write or grant is issued.
- R2: Register index 0 holds the source address, index 1 the destination address, and index 2 the count (only the low 24 bits are stored). Index 3 is the control word, in which only the defined fields are kept and every other bit reads 0.
  - Bit 0: enable.
  - Bit 1: finish status.
  - Bit 2: finish interrupt enable.
  - Bit 3: burst.
  - Bit 4: error status.
  - Bit 5: error interrupt enable.
  - Bit 6: source bus select.
  - Bit 7: destination bus select.
  - Bits 10:8: source step code.
  - Bits 14:12: destination step code.
  - Bits 19:16: destination request line.
  - Bits 27:24: source request line.
  - Bits 21:20: unit width.
- R3: Each beat has two handshakes:
  - A read handshake at the source address.
  - Then a write handshake that carries the read data to the destination address.
  - rd_sys and wr_sys copy control bits 6 and 7.
  - rd_size and wr_size give log2 of the unit bytes: width 00 gives 2, 01 gives 1, 10 gives 0, and the reserved 11 gives 2.
- R4: After every written beat each address changes by its step code. Code 000 (and the unused 100) leaves the address unchanged. Codes 001, 010 and 011 add 1, 2 and 4. Codes 101, 110 and 111 subtract 1, 2 and 4.
- R5: With burst set, one counted cycle is four beats and each step magnitude is multiplied by four. With burst clear, one cycle is one beat.
- R6: The count drops by one when each cycle completes, and reading it returns the cycles still to do. When it reaches 0 the channel sets the finish status, clears the enable and stops.
- R7: Enabling with a count of 0 sets the finish status and clears the enable without any read or write.
- R8: Request lines gate every cycle.
  - A nonzero line number n on either side holds every cycle until request input n (bit n-1) is high.
  - At the end of each cycle, grant bit n-1 of each selected line pulses for exactly one clock.
  - Line 0 means the side is unpaced.
- R9: An error response on a read or write handshake stops the channel at once and sets the error status. It also clears the enable, leaves the addresses and the count at the failing beat, and issues no write for a failed read.
- R10: Writing 0 to a status bit clears it, while writing 1 leaves it unchanged. A status set by hardware in the same cycle wins.
- R11: irq is high exactly when (finish status and finish enable) or (error status and error enable).
- R12: Writes to the address and count registers are ignored while the channel is busy.
- R13: Clearing the enable while the channel waits for a request returns it to idle with no status set and no further beats.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Selected register contents |
| rd_valid | output | 1 | Read request valid |
| rd_ready | input | 1 | Read accepted, data and error valid |
| rd_addr | output | ADDR_W | Read address |
| rd_sys | output | 1 | Read targets system bus (1) or peripheral bus (0) |
| rd_size | output | 2 | log2 of read unit bytes |
| rd_data | input | DATA_W | Read data |
| rd_err | input | 1 | Read error response |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Write accepted, error valid |
| wr_addr | output | ADDR_W | Write address |
| wr_sys | output | 1 | Write targets system bus (1) or peripheral bus (0) |
| wr_size | output | 2 | log2 of write unit bytes |
| wr_data | output | DATA_W | Write data |
| wr_err | input | 1 | Write error response |
| dreq | input | NUM_LINES | Peripheral request lines, bit n-1 is line n |
| dgnt | output | NUM_LINES | Peripheral grant pulses, bit n-1 is line n |
| irq | output | 1 | Level interrupt |

## Verification
The hardest state to reach from the ports is a paced channel stopped partway through: one cycle complete, the next held by a low request. This is where the residue, the single-clock grant and the register lock all have to be seen. The stimulus raises the request and watches the grant output at each falling edge. It drops the request in the same half-cycle as the first grant, so the sequencer is back in `S_WAIT` with one cycle done. A second scenario holds the request low from the start and then issues address, count and control writes into that waiting state.

// File: rtl/pdma_pkg.sv
package pdma_pkg;

    localparam int REG_W = 32;

    // control word bit positions
    localparam int C_EN     = 0;
    localparam int C_FIN    = 1;
    localparam int C_FIN_IE = 2;
    localparam int C_BURST  = 3;
    localparam int C_ERR    = 4;
    localparam int C_ERR_IE = 5;
    localparam int C_SRC_SYS = 6;
    localparam int C_DST_SYS = 7;
    localparam int C_SRC_STEP_LO = 8;
    localparam int C_DST_STEP_LO = 12;
    localparam int C_DST_LINE_LO = 16;
    localparam int C_WIDTH_LO    = 20;
    localparam int C_SRC_LINE_LO = 24;

    // bits taken directly from a software write
    localparam logic [REG_W-1:0] CTRL_WMASK  = 32'h0F3F_77ED;
    // bits that are cleared by writing zero
    localparam logic [REG_W-1:0] CTRL_STMASK = 32'h0000_0012;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WAIT,
        S_READ,
        S_WRITE,
        S_CLOSE,
        S_FINISH,
        S_FAULT
    } seq_state_t;

    function automatic logic [1:0] unit_log2(input logic [1:0] width);
        unique case (width)
            2'b01:   return 2'd1;
            2'b10:   return 2'd0;
            default: return 2'd2;
        endcase
    endfunction

endpackage

// File: rtl/pdma_addr_step.sv
module pdma_addr_step #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [2:0]        code,
    input  logic              burst,
    output logic [ADDR_W-1:0] nxt
);
    logic [ADDR_W-1:0] mag;

    always_comb begin
        unique case (code[1:0])
            2'd1:    mag = ADDR_W'(1);
            2'd2:    mag = ADDR_W'(2);
            2'd3:    mag = ADDR_W'(4);
            default: mag = '0;
        endcase
        if (burst) begin
            mag = mag << 2;
        end
        nxt = code[2] ? (addr - mag) : (addr + mag);
    end
endmodule

// File: rtl/pdma_regs.sv
module pdma_regs
    import pdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_sel,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic              busy,
    input  logic              beat_done,
    input  logic [ADDR_W-1:0] src_nxt,
    input  logic [ADDR_W-1:0] dst_nxt,
    input  logic              cnt_dec,
    input  logic              set_fin,
    input  logic              set_err,
    output logic [ADDR_W-1:0] src_q,
    output logic [ADDR_W-1:0] dst_q,
    output logic [CNT_W-1:0]  cnt_q,
    output logic [REG_W-1:0]  ctrl_q,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              irq
);
    logic [REG_W-1:0] ctrl_d;
    logic             sw_ok;

    assign sw_ok = reg_we && !busy;

    always_comb begin
        ctrl_d = ctrl_q;
        if (reg_we && reg_sel == 2'd3) begin
            ctrl_d = (reg_wdata & CTRL_WMASK) | (ctrl_q & reg_wdata & CTRL_STMASK);
        end
        if (set_fin) begin
            ctrl_d[C_FIN] = 1'b1;
            ctrl_d[C_EN]  = 1'b0;
        end
        if (set_err) begin
            ctrl_d[C_ERR] = 1'b1;
            ctrl_d[C_EN]  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q  <= '0;
            dst_q  <= '0;
            cnt_q  <= '0;
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
            if (beat_done) begin
                src_q <= src_nxt;
                dst_q <= dst_nxt;
            end else if (sw_ok && reg_sel == 2'd0) begin
                src_q <= reg_wdata[ADDR_W-1:0];
            end else if (sw_ok && reg_sel == 2'd1) begin
                dst_q <= reg_wdata[ADDR_W-1:0];
            end
            if (cnt_dec) begin
                cnt_q <= cnt_q - CNT_W'(1);
            end else if (sw_ok && reg_sel == 2'd2) begin
                cnt_q <= reg_wdata[CNT_W-1:0];
            end
        end
    end

    always_comb begin
        unique case (reg_sel)
            2'd0:    reg_rdata = REG_W'(src_q);
            2'd1:    reg_rdata = REG_W'(dst_q);
            2'd2:    reg_rdata = REG_W'(cnt_q);
            default: reg_rdata = ctrl_q;
        endcase
    end

    assign irq = (ctrl_q[C_FIN] & ctrl_q[C_FIN_IE]) | (ctrl_q[C_ERR] & ctrl_q[C_ERR_IE]);
endmodule

// File: rtl/pdma_seq.sv
module pdma_seq
    import pdma_pkg::*;
#(
    parameter int NUM_LINES   = 15,
    parameter int LINE_W      = 4,
    parameter int DATA_W      = 32,
    parameter int CNT_W       = 24,
    parameter int BURST_BEATS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic                 burst,
    input  logic [CNT_W-1:0]     cnt_q,
    input  logic [LINE_W-1:0]    src_line,
    input  logic [LINE_W-1:0]    dst_line,
    input  logic [NUM_LINES-1:0] dreq,
    input  logic                 rd_ready,
    input  logic                 rd_err,
    input  logic [DATA_W-1:0]    rd_data,
    input  logic                 wr_ready,
    input  logic                 wr_err,
    output logic                 rd_valid,
    output logic                 wr_valid,
    output logic [DATA_W-1:0]    wr_data,
    output logic                 beat_done,
    output logic                 cnt_dec,
    output logic                 set_fin,
    output logic                 set_err,
    output logic [NUM_LINES-1:0] dgnt,
    output logic                 busy
);
    localparam int BEAT_W = (BURST_BEATS > 1) ? $clog2(BURST_BEATS) : 1;

    seq_state_t        state_q, state_d;
    logic [BEAT_W-1:0] beat_q;
    logic [DATA_W-1:0] data_q;
    logic              src_ok, dst_ok, last_beat;

    always_comb begin
        src_ok = (src_line == '0);
        dst_ok = (dst_line == '0);
        for (int i = 0; i < NUM_LINES; i++) begin
            if (src_line == LINE_W'(i + 1) && dreq[i]) src_ok = 1'b1;
            if (dst_line == LINE_W'(i + 1) && dreq[i]) dst_ok = 1'b1;
        end
    end

    assign last_beat = !burst || (beat_q == BEAT_W'(BURST_BEATS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d   = state_q;
        rd_valid  = 1'b0;
        wr_valid  = 1'b0;
        beat_done = 1'b0;
        cnt_dec   = 1'b0;
        set_fin   = 1'b0;
        set_err   = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (en) state_d = (cnt_q == '0) ? S_FINISH : S_WAIT;
            end
            S_WAIT: begin
                if (!en) state_d = S_IDLE;
                else if (src_ok && dst_ok) state_d = S_READ;
            end
            S_READ: begin
                rd_valid = 1'b1;
                if (rd_ready) state_d = rd_err ? S_FAULT : S_WRITE;
            end
            S_WRITE: begin
                wr_valid = 1'b1;
                if (wr_ready) begin
                    if (wr_err) begin
                        state_d = S_FAULT;
                    end else begin
                        beat_done = 1'b1;
                        state_d = last_beat ? S_CLOSE : S_READ;
                    end
                end
            end
            S_CLOSE: begin
                cnt_dec = 1'b1;
                state_d = (cnt_q == CNT_W'(1)) ? S_FINISH : S_WAIT;
            end
            S_FINISH: begin
                set_fin = 1'b1;
                state_d = S_IDLE;
            end
            S_FAULT: begin
                set_err = 1'b1;
                state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beat_q <= '0;
            data_q <= '0;
        end else begin
            if (state_q == S_WAIT) begin
                beat_q <= '0;
            end else if (beat_done) begin
                beat_q <= beat_q + BEAT_W'(1);
            end
            if (rd_valid && rd_ready && !rd_err) begin
                data_q <= rd_data;
            end
        end
    end

    assign wr_data = data_q;
    assign busy    = (state_q != S_IDLE);

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_gnt
        assign dgnt[g] = (state_q == S_CLOSE) &&
                         ((src_line == LINE_W'(g + 1)) || (dst_line == LINE_W'(g + 1)));
    end
endmodule

// File: rtl/pdma_channel.sv
module pdma_channel
    import pdma_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int CNT_W       = 24,
    parameter int NUM_LINES   = 15,
    parameter int BURST_BEATS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_we,
    input  logic [1:0]           reg_sel,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    output logic                 rd_valid,
    input  logic                 rd_ready,
    output logic [ADDR_W-1:0]    rd_addr,
    output logic                 rd_sys,
    output logic [1:0]           rd_size,
    input  logic [DATA_W-1:0]    rd_data,
    input  logic                 rd_err,
    output logic                 wr_valid,
    input  logic                 wr_ready,
    output logic [ADDR_W-1:0]    wr_addr,
    output logic                 wr_sys,
    output logic [1:0]           wr_size,
    output logic [DATA_W-1:0]    wr_data,
    input  logic                 wr_err,
    input  logic [NUM_LINES-1:0] dreq,
    output logic [NUM_LINES-1:0] dgnt,
    output logic                 irq
);
    localparam int LINE_W = 4;

    logic [ADDR_W-1:0] src_q, dst_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [REG_W-1:0]  ctrl_q;
    logic              busy, beat_done, cnt_dec, set_fin, set_err;
    logic [ADDR_W-1:0] side_cur [2];
    logic [ADDR_W-1:0] side_nxt [2];
    logic [2:0]        side_code [2];

    assign side_cur[0]  = src_q;
    assign side_cur[1]  = dst_q;
    assign side_code[0] = ctrl_q[C_SRC_STEP_LO +: 3];
    assign side_code[1] = ctrl_q[C_DST_STEP_LO +: 3];

    for (genvar s = 0; s < 2; s++) begin : g_side
        pdma_addr_step #(.ADDR_W(ADDR_W)) u_step (
            .addr  (side_cur[s]),
            .code  (side_code[s]),
            .burst (ctrl_q[C_BURST]),
            .nxt   (side_nxt[s])
        );
    end

    pdma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .busy      (busy),
        .beat_done (beat_done),
        .src_nxt   (side_nxt[0]),
        .dst_nxt   (side_nxt[1]),
        .cnt_dec   (cnt_dec),
        .set_fin   (set_fin),
        .set_err   (set_err),
        .src_q     (src_q),
        .dst_q     (dst_q),
        .cnt_q     (cnt_q),
        .ctrl_q    (ctrl_q),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    pdma_seq #(
        .NUM_LINES   (NUM_LINES),
        .LINE_W      (LINE_W),
        .DATA_W      (DATA_W),
        .CNT_W       (CNT_W),
        .BURST_BEATS (BURST_BEATS)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (ctrl_q[C_EN]),
        .burst     (ctrl_q[C_BURST]),
        .cnt_q     (cnt_q),
        .src_line  (ctrl_q[C_SRC_LINE_LO +: LINE_W]),
        .dst_line  (ctrl_q[C_DST_LINE_LO +: LINE_W]),
        .dreq      (dreq),
        .rd_ready  (rd_ready),
        .rd_err    (rd_err),
        .rd_data   (rd_data),
        .wr_ready  (wr_ready),
        .wr_err    (wr_err),
        .rd_valid  (rd_valid),
        .wr_valid  (wr_valid),
        .wr_data   (wr_data),
        .beat_done (beat_done),
        .cnt_dec   (cnt_dec),
        .set_fin   (set_fin),
        .set_err   (set_err),
        .dgnt      (dgnt),
        .busy      (busy)
    );

    assign rd_addr = src_q;
    assign wr_addr = dst_q;
    assign rd_sys  = ctrl_q[C_SRC_SYS];
    assign wr_sys  = ctrl_q[C_DST_SYS];
    assign rd_size = unit_log2(ctrl_q[C_WIDTH_LO +: 2]);
    assign wr_size = rd_size;
endmodule

// File: rtl/pdma_channel_chk.sv
module pdma_channel_chk #(
    parameter int ADDR_W    = 32,
    parameter int CNT_W     = 24,
    parameter int NUM_LINES = 15
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 irq,
    input logic                 fin_ie,
    input logic                 err_ie,
    input logic [NUM_LINES-1:0] dgnt,
    input logic                 rd_valid,
    input logic                 rd_ready,
    input logic                 rd_err,
    input logic [ADDR_W-1:0]    rd_addr,
    input logic                 wr_valid,
    input logic [CNT_W-1:0]     cnt_q
);
    // R11
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fin_ie && !err_ie) |-> !irq);

    // R8
    grant_single_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|dgnt) |=> !(|dgnt));

    // R3
    read_request_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)));

    // R9
    no_write_after_read_error_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_ready && rd_err) |=> !wr_valid);

    // R6
    beats_only_with_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid || wr_valid) |-> (cnt_q != '0));

    // R3
    read_write_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_valid && wr_valid));
endmodule

bind pdma_channel pdma_channel_chk #(
    .ADDR_W    (ADDR_W),
    .CNT_W     (CNT_W),
    .NUM_LINES (NUM_LINES)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq      (irq),
    .fin_ie   (ctrl_q[2]),
    .err_ie   (ctrl_q[5]),
    .dgnt     (dgnt),
    .rd_valid (rd_valid),
    .rd_ready (rd_ready),
    .rd_err   (rd_err),
    .rd_addr  (rd_addr),
    .wr_valid (wr_valid),
    .cnt_q    (cnt_q)
);

// File: tb/pdma_channel_bench.sv
`timescale 1ns/1ps
module pdma_channel_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        rd_valid, rd_sys, wr_valid, wr_sys, irq;
    logic        rd_ready = 1'b1;
    logic        wr_ready = 1'b1;
    logic [31:0] rd_addr, wr_addr, rd_data, wr_data;
    logic [1:0]  rd_size, wr_size;
    logic        rd_err, wr_err;
    logic [14:0] dreq = '0;
    logic [14:0] dgnt;
    logic        err_on = 1'b0;
    logic [31:0] err_addr = '0;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    function automatic logic [31:0] pat(input logic [31:0] a);
        return {a[15:0], ~a[15:0]};
    endfunction

    assign rd_data = pat(rd_addr);
    assign rd_err  = err_on && (rd_addr == err_addr);
    assign wr_err  = 1'b0;

    pdma_channel u_pdma_channel (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_sys(rd_sys),
        .rd_size(rd_size), .rd_data(rd_data), .rd_err(rd_err),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_sys(wr_sys),
        .wr_size(wr_size), .wr_data(wr_data), .wr_err(wr_err),
        .dreq(dreq), .dgnt(dgnt), .irq(irq)
    );

    // transaction logs, sampled at the falling edge
    logic [31:0] wl_a [0:63];
    logic [31:0] wl_d [0:63];
    logic [1:0]  wl_sz [0:63];
    logic        wl_sys [0:63];
    int          wn = 0;
    int          rn = 0;
    int          gsamp [0:14];
    logic        rsys_last = 1'b0;
    logic [1:0]  rsz_last = 2'd0;

    initial for (int i = 0; i < 15; i++) gsamp[i] = 0;

    always @(negedge clk) begin
        if (wr_valid && wr_ready && wn < 64) begin
            wl_a[wn]   = wr_addr;
            wl_d[wn]   = wr_data;
            wl_sz[wn]  = wr_size;
            wl_sys[wn] = wr_sys;
            wn++;
        end
        if (rd_valid && rd_ready) begin
            rsys_last = rd_sys;
            rsz_last  = rd_size;
            rn++;
        end
        for (int i = 0; i < 15; i++) if (dgnt[i]) gsamp[i]++;
    end

    function automatic int gtotal();
        int t = 0;
        for (int i = 0; i < 15; i++) t += gsamp[i];
        return t;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] sel, input logic [31:0] val);
        @(negedge clk);
        reg_sel = sel; reg_wdata = val; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] sel, output logic [31:0] val);
        @(negedge clk);
        reg_sel = sel;
        #1 val = reg_rdata;
    endtask

    task automatic wait_stop();
        logic [31:0] v;
        for (int i = 0; i < 500; i++) begin
            reg_read(2'd3, v);
            if (!v[0]) break;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic setup(input logic [31:0] s, input logic [31:0] d, input logic [31:0] c);
        reg_write(2'd0, s);
        reg_write(2'd1, d);
        reg_write(2'd2, c);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int i = 0; i < 4; i++) begin
            reg_read(2'(i), v);
            chk("R1 register reset", v, 32'h0);
        end
        chk("R1 irq reset", {31'b0, irq}, 32'h0);
        chk("R1 no traffic", rd_valid | wr_valid | (|dgnt), 32'h0);
    endtask

    task automatic t_regmap();
        logic [31:0] v;
        setup(32'h1111_2222, 32'h3333_4444, 32'hFFFF_FFFF);
        reg_read(2'd0, v); chk("R2 source readback", v, 32'h1111_2222);
        reg_read(2'd1, v); chk("R2 destination readback", v, 32'h3333_4444);
        reg_read(2'd2, v); chk("R2 count 24 bits", v, 32'h00FF_FFFF);
        reg_write(2'd3, 32'hFFFF_FFFE);
        reg_read(2'd3, v); chk("R2 control mask", v, 32'h0F3F_77EC);
        reg_write(2'd3, 32'h0);
        reg_read(2'd3, v); chk("R2 control cleared", v, 32'h0);
    endtask

    task automatic t_basic();
        logic [31:0] v;
        int wb = wn;
        setup(32'h100, 32'h800, 32'd3);
        reg_write(2'd3, 32'h0000_3345);
        wait_stop();
        chk("R3 beat count", 32'(wn - wb), 32'd3);
        for (int i = 0; i < 3; i++) begin
            chk("R4 increment dest address", wl_a[wb + i], 32'h800 + 32'(4 * i));
            chk("R3 data copied", wl_d[wb + i], pat(32'h100 + 32'(4 * i)));
            chk("R3 word size", {30'b0, wl_sz[wb + i]}, 32'd2);
            chk("R3 dest bus select", {31'b0, wl_sys[wb + i]}, 32'd0);
        end
        chk("R3 source bus select", {31'b0, rsys_last}, 32'd1);
        chk("R3 read size", {30'b0, rsz_last}, 32'd2);
        reg_read(2'd2, v); chk("R6 count at end", v, 32'd0);
        reg_read(2'd3, v); chk("R6 finish sets status clears enable", v, 32'h0000_3346);
        reg_read(2'd0, v); chk("R4 source stepped", v, 32'h10C);
        chk("R11 irq on finish", {31'b0, irq}, 32'd1);
        reg_write(2'd3, 32'h0000_3344);
        reg_read(2'd3, v); chk("R10 write zero clears finish", v, 32'h0000_3344);
        chk("R11 irq low after clear", {31'b0, irq}, 32'd0);
        reg_write(2'd3, 32'h0);
    endtask

    task automatic t_dec_byte();
        logic [31:0] v;
        int wb = wn;
        setup(32'h40, 32'h203, 32'd2);
        reg_write(2'd3, 32'h0020_5001);
        wait_stop();
        chk("R4 byte beats", 32'(wn - wb), 32'd2);
        chk("R4 decrement first", wl_a[wb], 32'h203);
        chk("R4 decrement second", wl_a[wb + 1], 32'h202);
        chk("R4 fixed source data", wl_d[wb + 1], pat(32'h40));
        chk("R3 byte size", {30'b0, wl_sz[wb]}, 32'd0);
        reg_read(2'd1, v); chk("R4 dest after", v, 32'h201);
        reg_read(2'd3, v); chk("R6 finish no enable", v, 32'h0020_5002);
        chk("R11 irq gated off", {31'b0, irq}, 32'd0);
        reg_write(2'd3, 32'h0);
    endtask

    task automatic t_burst();
        logic [31:0] v;
        int wb = wn;
        setup(32'h1000, 32'h2000, 32'd2);
        reg_write(2'd3, 32'h0000_01C9);
        wait_stop();
        chk("R5 burst beats", 32'(wn - wb), 32'd8);
        for (int i = 0; i < 8; i++) begin
            chk("R5 fixed dest", wl_a[wb + i], 32'h2000);
            chk("R5 scaled source step", wl_d[wb + i], pat(32'h1000 + 32'(4 * i)));
        end
        chk("R3 system bus dest", {31'b0, wl_sys[wb]}, 32'd1);
        reg_read(2'd2, v); chk("R5 count after burst", v, 32'd0);
        reg_read(2'd0, v); chk("R5 source after burst", v, 32'h1020);
        reg_write(2'd3, 32'h0);
    endtask

    task automatic t_paced();
        logic [31:0] v;
        int wb = wn;
        int g2 = gsamp[2];
        int gt = gtotal();
        int n;
        setup(32'h600, 32'h700, 32'd2);
        reg_write(2'd3, 32'h0300_3301);
        repeat (20) @(negedge clk);
        chk("R8 no beat without request", 32'(wn - wb), 32'd0);
        dreq[2] = 1'b1;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!dgnt[2] && n < 100);
        dreq[2] = 1'b0;
        repeat (10) @(negedge clk);
        chk("R8 one cycle per request", 32'(wn - wb), 32'd1);
        reg_read(2'd2, v); chk("R6 residue mid transfer", v, 32'd1);
        chk("R8 grant one clock", 32'(gsamp[2] - g2), 32'd1);
        chk("R8 only selected grant", 32'(gtotal() - gt), 32'd1);
        dreq[2] = 1'b1;
        wait_stop();
        dreq[2] = 1'b0;
        chk("R8 second cycle", 32'(wn - wb), 32'd2);
        chk("R8 second grant", 32'(gsamp[2] - g2), 32'd2);
        reg_read(2'd3, v); chk("R6 paced finish", v, 32'h0300_3302);
        reg_write(2'd3, 32'h0);
    endtask

    task automatic t_error();
        logic [31:0] v;
        int wb = wn;
        setup(32'h300, 32'h900, 32'd4);
        err_addr = 32'h308;
        err_on = 1'b1;
        reg_write(2'd3, 32'h0000_3321);
        wait_stop();
        err_on = 1'b0;
        chk("R9 writes before error", 32'(wn - wb), 32'd2);
        reg_read(2'd3, v); chk("R9 error status", v, 32'h0000_3330);
        reg_read(2'd2, v); chk("R9 count at failure", v, 32'd2);
        reg_read(2'd0, v); chk("R9 source held", v, 32'h308);
        chk("R11 irq on error", {31'b0, irq}, 32'd1);
        reg_write(2'd3, 32'h0000_3330);
        reg_read(2'd3, v); chk("R10 write one keeps error", v, 32'h0000_3330);
        reg_write(2'd3, 32'h0);
        reg_read(2'd3, v); chk("R10 write zero clears error", v, 32'h0);
        chk("R11 irq cleared", {31'b0, irq}, 32'd0);
    endtask

    task automatic t_zero();
        logic [31:0] v;
        int rb = rn;
        reg_write(2'd2, 32'd0);
        reg_write(2'd3, 32'h0000_0005);
        wait_stop();
        chk("R7 no reads", 32'(rn - rb), 32'd0);
        reg_read(2'd3, v); chk("R7 immediate finish", v, 32'h0000_0006);
        chk("R7 irq", {31'b0, irq}, 32'd1);
        reg_write(2'd3, 32'h0);
    endtask

    task automatic t_lock_abort();
        logic [31:0] v;
        int wb = wn;
        setup(32'h500, 32'h580, 32'd5);
        reg_write(2'd3, 32'h0004_0001);
        repeat (5) @(negedge clk);
        reg_write(2'd0, 32'h999);
        reg_write(2'd1, 32'hAAA);
        reg_write(2'd2, 32'd1);
        reg_read(2'd0, v); chk("R12 source locked", v, 32'h500);
        reg_read(2'd1, v); chk("R12 dest locked", v, 32'h580);
        reg_read(2'd2, v); chk("R12 count locked", v, 32'd5);
        reg_write(2'd3, 32'h0);
        repeat (5) @(negedge clk);
        reg_read(2'd3, v); chk("R13 abort no status", v, 32'h0);
        chk("R13 no beats", 32'(wn - wb), 32'd0);
        reg_write(2'd2, 32'd7);
        reg_read(2'd2, v); chk("R13 idle after abort", v, 32'd7);
    endtask

    initial begin
        #(1ms);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd0, 32'd1);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_regmap();
        t_basic();
        t_dec_byte();
        t_burst();
        t_paced();
        t_error();
        t_zero();
        t_lock_abort();
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule